// File: doc/BRIEF.md
# Vectored Interrupt Fielder with Grant Chain

This block collects interrupt requests from up to `N_SLOTS` devices that sit along a grant chain. Every slot can raise a request at any of four priority levels, from 1 (lowest) to 4 (highest). A raised request stays latched until it is served. The block compares the pending levels against the processor's current priority and signals the processor when some level is strictly above it.

When the processor starts an acknowledge cycle, the block freezes the highest eligible level. It then sends a grant into slot 0, and the grant moves one slot further down the chain on each clock. The first slot that holds a request at the frozen level absorbs the grant and supplies its vector. The block returns that vector, word-aligned, together with the level, and clears only the served request. If no slot absorbs the grant within a timeout, the acknowledge ends with an error flag and no vector.

Top module: `irq_fielder`

## Requirements
- R1: A one-cycle pulse on `req_set_i[s*4 + L-1]` latches a request for slot `s` at level `L` (1..4). The request stays pending until that slot is served at level `L`.
- R2: `irq_o` is high exactly when some pending level is strictly greater than `cpu_pri_i` (0..4). `irq_lvl_o` gives the highest such level, and gives 0 when there is none.
- R3: `iak_i` sampled while no acknowledge is running starts one, frozen at the current `irq_lvl_o` (0 if nothing is eligible). `iak_i` sampled while an acknowledge is running is ignored.
- R4: The grant enters slot 0 on the first edge after `iak_i` and advances one slot per clock. The lowest-numbered slot with a request at the frozen level wins, and `ack_done_o` rises after edge s+1 counted from the `iak_i` edge.
- R5: On success, `ack_vec_o` equals the winner's 9-bit `dev_vec_i` field with bits [1:0] forced to zero, `ack_lvl_o` is the frozen level, and `ack_err_o` is 0.
- R6: Only the winner's request at the acknowledged level is cleared. Every other pending request, including the winner's requests at other levels, stays latched.
- R7: If no slot claims the grant, the acknowledge ends `TMO_CYCLES` edges after the `iak_i` edge with `ack_err_o`=1, `ack_vec_o`=0 and `ack_lvl_o` equal to the frozen level.
- R8: `ack_done_o` is a one-cycle pulse. `ack_vec_o`, `ack_lvl_o` and `ack_err_o` hold their values until the next completion.
- R9: After reset, no request is pending, and `irq_o`, `irq_lvl_o`, `ack_done_o`, `ack_vec_o`, `ack_lvl_o` and `ack_err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_set_i | input | N_SLOTS*4 | Request pulses, one per slot and level |
| dev_vec_i | input | N_SLOTS*9 | Vector offered by each slot |
| cpu_pri_i | input | 3 | Current processor priority, 0..4 |
| iak_i | input | 1 | Start an acknowledge cycle |
| irq_o | output | 1 | A request above the processor priority is pending |
| irq_lvl_o | output | 3 | Highest eligible level, 0 when none |
| ack_done_o | output | 1 | Acknowledge completed (one-cycle pulse) |
| ack_vec_o | output | 9 | Returned vector, word-aligned |
| ack_lvl_o | output | 3 | Level that was acknowledged |
| ack_err_o | output | 1 | No device claimed the grant |

## Verification
The bench goes after several corner cases, and each maps to a specific defect it would expose:
- Two slots request at the same level. A design that ranks slots wrongly returns the farther slot's vector.
- One slot requests at three levels at once. A design that clears the whole slot loses the two lower requests, and the following acknowledges fail.
- A request sits exactly at, or below, the processor priority. A design that uses a non-strict compare raises `irq_o`.
- An acknowledge is issued with nothing eligible. This must time out on the exact cycle with a zero vector, and a design with a wrong counter ends early or late.
- A second `iak_i` arrives mid-cycle. A design that re-arms on it restarts the grant or produces a second completion.
- The completion latency is measured for every winner, which exposes a grant that skips or stalls.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_LVL = 4;
  localparam int LVL_W   = $clog2(NUM_LVL + 1);
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_lvl_pick.sv
module irq_lvl_pick
  import irq_pkg::*;
(
  input  logic [NUM_LVL-1:0] lvl_pend_i,
  input  lvl_t               pri_i,
  output logic               irq_o,
  output lvl_t               lvl_o
);
  // ascending scan: last hit is the highest eligible level
  always_comb begin
    lvl_o = '0;
    for (int l = 1; l <= NUM_LVL; l++) begin
      if (lvl_pend_i[l-1] && (LVL_W'(l) > pri_i)) lvl_o = LVL_W'(l);
    end
    irq_o = (lvl_o != '0);
  end
endmodule

// File: rtl/irq_slot.sv
module irq_slot
  import irq_pkg::*;
#(
  parameter int VEC_W = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_LVL-1:0] set_i,
  input  logic               gnt_i,
  input  lvl_t               lvl_i,
  input  logic [VEC_W-1:0]   vec_i,
  output logic [NUM_LVL-1:0] pend_o,
  output logic               claim_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic [NUM_LVL-1:0] pend_q, hit;

  always_comb begin
    for (int l = 0; l < NUM_LVL; l++) hit[l] = (lvl_i == LVL_W'(l + 1));
  end

  assign claim_o = gnt_i & |(hit & pend_q);
  assign vec_o   = claim_o ? vec_i : '0;
  assign pend_o  = pend_q;

  // a new request wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= set_i | (pend_q & ~(hit & {NUM_LVL{claim_o}}));
  end

  AST_CLAIM_CLEARS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_o && set_i == '0) |=> ($countones(pend_q) + 1 == $countones($past(pend_q)))); // R6
endmodule

// File: rtl/irq_fielder.sv
module irq_fielder
  import irq_pkg::*;
#(
  parameter int N_SLOTS    = 8,
  parameter int VEC_W      = 9,
  parameter int TMO_CYCLES = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_SLOTS*NUM_LVL-1:0] req_set_i,
  input  logic [N_SLOTS*VEC_W-1:0]   dev_vec_i,
  input  logic [LVL_W-1:0]           cpu_pri_i,
  input  logic                       iak_i,
  output logic                       irq_o,
  output logic [LVL_W-1:0]           irq_lvl_o,
  output logic                       ack_done_o,
  output logic [VEC_W-1:0]           ack_vec_o,
  output logic [LVL_W-1:0]           ack_lvl_o,
  output logic                       ack_err_o
);
  localparam int TMO_W = $clog2(TMO_CYCLES + 1);

  logic [N_SLOTS-1:0]              gnt_q, gnt_d, claim;
  logic [N_SLOTS-1:0][NUM_LVL-1:0] pend;
  logic [N_SLOTS-1:0][VEC_W-1:0]   slot_vec;
  logic [NUM_LVL-1:0]              lvl_any;
  logic [VEC_W-1:0]                win_vec;
  lvl_t                            pick_lvl, ack_lvl_q;
  logic                            busy_q, expire;
  logic [TMO_W-1:0]                tmo_q;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    irq_slot #(.VEC_W(VEC_W)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (req_set_i[s*NUM_LVL +: NUM_LVL]),
      .gnt_i   (gnt_q[s]),
      .lvl_i   (ack_lvl_q),
      .vec_i   (dev_vec_i[s*VEC_W +: VEC_W]),
      .pend_o  (pend[s]),
      .claim_o (claim[s]),
      .vec_o   (slot_vec[s])
    );
  end

  always_comb begin
    lvl_any = '0;
    win_vec = '0;
    for (int s = 0; s < N_SLOTS; s++) begin
      lvl_any = lvl_any | pend[s];
      win_vec = win_vec | slot_vec[s];
    end
  end

  irq_lvl_pick u_pick (
    .lvl_pend_i (lvl_any),
    .pri_i      (cpu_pri_i),
    .irq_o      (irq_o),
    .lvl_o      (pick_lvl)
  );
  assign irq_lvl_o = pick_lvl;

  assign expire = busy_q && (claim == '0) && (tmo_q == TMO_W'(TMO_CYCLES - 1));

  // grant ripples one slot per clock; a claiming slot does not pass it on
  always_comb begin
    gnt_d[0] = !busy_q && iak_i;
    for (int s = 1; s < N_SLOTS; s++) gnt_d[s] = gnt_q[s-1] && !claim[s-1] && !expire;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= '0;
    else         gnt_q <= gnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      ack_lvl_q  <= '0;
      tmo_q      <= '0;
      ack_done_o <= 1'b0;
      ack_vec_o  <= '0;
      ack_lvl_o  <= '0;
      ack_err_o  <= 1'b0;
    end else begin
      ack_done_o <= 1'b0;
      if (!busy_q) begin
        if (iak_i) begin
          busy_q    <= 1'b1;
          ack_lvl_q <= pick_lvl;
          tmo_q     <= '0;
        end
      end else if (claim != '0) begin
        busy_q     <= 1'b0;
        ack_done_o <= 1'b1;
        ack_vec_o  <= {win_vec[VEC_W-1:2], 2'b00};
        ack_lvl_o  <= ack_lvl_q;
        ack_err_o  <= 1'b0;
      end else if (expire) begin
        busy_q     <= 1'b0;
        ack_done_o <= 1'b1;
        ack_vec_o  <= '0;
        ack_lvl_o  <= ack_lvl_q;
        ack_err_o  <= 1'b1;
      end else begin
        tmo_q <= tmo_q + 1'b1;
      end
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q)); // R4
  AST_GNT_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q != '0) |-> busy_q); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_done_o |=> !ack_done_o); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_done_o |-> ($stable(ack_vec_o) && $stable(ack_err_o) && $stable(ack_lvl_o))); // R8
  AST_TMO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (tmo_q < TMO_W'(TMO_CYCLES))); // R7
  AST_ERR_NO_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_done_o && ack_err_o) |-> (ack_vec_o == '0)); // R7
endmodule

// File: tb/tb_irq_fielder.sv
`timescale 1ns/1ps
module tb_irq_fielder;
  localparam int N   = 8;
  localparam int TMO = 12;
  localparam int NT  = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N*4-1:0] req_set = '0;
  logic [N*9-1:0] dev_vec;
  logic [2:0]    pri = '0;
  logic          iak = 1'b0;
  logic          irq, done, err;
  logic [2:0]    irq_lvl, ack_lvl;
  logic [8:0]    vec;
  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  irq_fielder #(.N_SLOTS(N), .VEC_W(9), .TMO_CYCLES(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_set_i(req_set), .dev_vec_i(dev_vec),
    .cpu_pri_i(pri), .iak_i(iak), .irq_o(irq), .irq_lvl_o(irq_lvl),
    .ack_done_o(done), .ack_vec_o(vec), .ack_lvl_o(ack_lvl), .ack_err_o(err));

  // {set mask, pri, exp irq, exp level, exp err, exp slot}
  localparam logic [42:0] TBL [NT] = '{
    {32'h00200200, 3'd0, 1'b1, 3'd2, 1'b0, 3'd2},
    {32'h00000000, 3'd0, 1'b1, 3'd2, 1'b0, 3'd5},
    {32'h10000040, 3'd2, 1'b1, 3'd3, 1'b0, 3'd1},
    {32'h00000000, 3'd1, 1'b0, 3'd0, 1'b1, 3'd0},
    {32'h00008000, 3'd4, 1'b0, 3'd0, 1'b1, 3'd0},
    {32'h00000000, 3'd3, 1'b1, 3'd4, 1'b0, 3'd3},
    {32'h08000001, 3'd0, 1'b1, 3'd4, 1'b0, 3'd6},
    {32'h00000000, 3'd0, 1'b1, 3'd1, 1'b0, 3'd0},
    {32'h00000000, 3'd0, 1'b1, 3'd1, 1'b0, 3'd7},
    {32'h00070000, 3'd0, 1'b1, 3'd3, 1'b0, 3'd4},
    {32'h00000000, 3'd0, 1'b1, 3'd2, 1'b0, 3'd4},
    {32'h00000000, 3'd0, 1'b1, 3'd1, 1'b0, 3'd4}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // drive iak at the current negedge, return negedges until done is seen
  task automatic do_ack(output int lat);
    iak = 1'b1;
    lat = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      iak = 1'b0;
      if (done) begin
        lat = k;
        break;
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      total++;
      $display("FAIL R4 watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat;
    for (int s = 0; s < N; s++) dev_vec[s*9 +: 9] = 9'(64 + s*8 + 3);
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 irq", irq, 0);
    check("R9 irq_lvl", irq_lvl, 0);
    check("R9 done", done, 0);
    check("R9 vec", vec, 0);
    check("R9 err", err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 irq after release", irq, 0);

    for (int i = 0; i < NT; i++) begin
      logic [31:0] m;
      logic [2:0]  p, el;
      logic        ei, ee;
      logic [2:0]  es;
      {m, p, ei, el, ee, es} = TBL[i];
      req_set = m;
      pri = p;
      @(negedge clk);
      req_set = '0;
      check("R1/R2 irq", irq, ei);
      check("R2 irq_lvl", irq_lvl, el);
      do_ack(lat);
      check("R3/R5 ack_lvl", ack_lvl, el);
      if (ee) begin
        check("R7 err", err, 1);
        check("R7 vec", vec, 0);
        check("R7 latency", lat, TMO + 1);
      end else begin
        check("R4/R6 err", err, 0);
        check("R5 vec", vec, 64 + es*8);
        check("R4 latency", lat, es + 2);
      end
      @(negedge clk);
      check("R8 done pulse", done, 0);
      check("R8 vec hold", vec, ee ? 0 : 64 + es*8);
    end
    pri = 3'd0;
    @(negedge clk);
    check("R6 all served", irq, 0);

    // R3 second iak during a running acknowledge is ignored
    req_set = 32'h02000000; // slot 6 level 2
    @(negedge clk);
    req_set = '0;
    check("R1 irq slot6", irq_lvl, 2);
    iak = 1'b1;
    lat = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      iak = (k == 2);
      if (done) begin
        lat = k;
        break;
      end
    end
    iak = 1'b0;
    check("R3 latency unchanged", lat, 8);
    check("R3 vec", vec, 64 + 6*8);
    begin
      int extra = 0;
      for (int k = 0; k < TMO + 8; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check("R3 no second completion", extra, 0);
    end
    check("R8 err holds", err, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule